// File: doc/BRIEF.md
# Accumulator ALU with Carry and Zero Flags

This block is the arithmetic and logic datapath of a small accumulator machine. Each cycle it takes the 8-bit accumulator value, an 8-bit operand and a 3-bit operation code. It returns the value to write back to the accumulator, an enable for that write-back, and the next carry and zero flag values with per-flag update enables. It holds the carry flag C and the zero flag Z in its own register.

The operations are bitwise AND and OR, add, subtract, compare, rotate left and right through carry, and clear flags. Each operation changes only its own subset of the flags. Compare sets the flags but does not write the accumulator. Both rotates run over 9 bits, the eight accumulator bits plus C.

All outputs except the flag register are combinational in the current inputs and the stored flags. The flag register loads on a rising clock edge only while the execute strobe is high. The core that drives the block fetches and decodes instructions, writes the accumulator and reaches memory.

Top module: `acc_alu_flags`

## Requirements
- R1: With op 0 (AND) or op 1 (OR), result is the bitwise AND or OR of accumulator and operand. Write-back is asserted, Z is updated to (result == 0), and C keeps its value.
- R2: With op 2 (ADD), result is (acc + operand) mod 256 and write-back is asserted. C takes the carry out of bit 7 and Z takes (result == 0).
- R3: With op 3 (SUB), result is (acc - operand) mod 256 and write-back is asserted. C takes the borrow (operand > acc, unsigned) and Z takes (result == 0).
- R4: With op 4 (CMP), write-back is deasserted and the accumulator is not changed. C becomes (operand > acc) and Z becomes (operand == acc). result carries the discarded difference.
- R5: With op 5 (ROL), result is {acc[6:0], C} and write-back is asserted. C becomes acc[7] and Z keeps its value.
- R6: With op 6 (ROR), result is {C, acc[7:1]} and write-back is asserted. C becomes acc[0] and Z keeps its value.
- R7: With op 7 (CLF), C and Z both become 0, write-back is deasserted and result equals the accumulator input.
- R8: Reset (rst_n low) clears C and Z. The flag register changes only on a rising edge with exec_i high. With exec_i low the flags hold for any op.
- R9: The stored C is never added into ADD or subtracted in SUB or CMP: the results are the same for C = 0 and C = 1.
- R10: result_o and acc_we_o follow the inputs in the same cycle, with no register between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the flags |
| exec_i | input | 1 | Execute strobe; the flags load at the edge while high |
| op_i | input | 3 | Operation code (0 AND, 1 OR, 2 ADD, 3 SUB, 4 CMP, 5 ROL, 6 ROR, 7 CLF) |
| acc_i | input | 8 | Current accumulator value |
| opnd_i | input | 8 | Operand value |
| result_o | output | 8 | Value for the accumulator (difference for CMP) |
| acc_we_o | output | 1 | Accumulator write-back enable |
| c_nxt_o | output | 1 | Next carry value |
| z_nxt_o | output | 1 | Next zero value |
| c_we_o | output | 1 | The op changes C |
| z_we_o | output | 1 | The op changes Z |
| c_o | output | 1 | Stored carry flag |
| z_o | output | 1 | Stored zero flag |

## Verification
result_o and acc_we_o are due in the same cycle as the inputs. The monitor samples them a quarter period after the driver applies the inputs on the falling edge, before the next rising edge can change the stored carry that the rotates read. The stored flags are due one rising edge later. The monitor reads c_o and z_o just after that edge and compares them with the flags the scoreboard item predicted, including items driven with the strobe low.

// File: rtl/alu_pkg.sv
package alu_pkg;

    localparam int unsigned DW = 8;

    typedef enum logic [2:0] {
        OP_AND = 3'd0,
        OP_OR  = 3'd1,
        OP_ADD = 3'd2,
        OP_SUB = 3'd3,
        OP_CMP = 3'd4,
        OP_ROL = 3'd5,
        OP_ROR = 3'd6,
        OP_CLF = 3'd7
    } alu_op_e;

    typedef struct packed {
        logic c;
        logic z;
    } flags_t;

    typedef struct packed {
        logic [DW-1:0] res;
        logic          acc_we;
        logic          c_val;
        logic          z_val;
        logic          c_we;
        logic          z_we;
    } alu_out_t;

endpackage

// File: rtl/alu_logic_unit.sv
module alu_logic_unit #(
    parameter int unsigned W = 8
) (
    input  logic         sel_or_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] res_o
);
    always_comb begin
        if (sel_or_i) res_o = a_i | b_i;
        else          res_o = a_i & b_i;
    end
endmodule

// File: rtl/alu_arith_unit.sv
module alu_arith_unit #(
    parameter int unsigned W = 8
) (
    input  logic         sub_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] res_o,
    output logic         cy_o
);
    localparam int unsigned XW = W + 1;
    logic [XW-1:0] wide;

    always_comb begin
        if (sub_i) wide = {1'b0, a_i} - {1'b0, b_i};
        else       wide = {1'b0, a_i} + {1'b0, b_i};
        res_o = wide[W-1:0];
        cy_o  = wide[XW-1];
    end
endmodule

// File: rtl/alu_rot_unit.sv
module alu_rot_unit #(
    parameter int unsigned W = 8
) (
    input  logic         right_i,
    input  logic         cin_i,
    input  logic [W-1:0] a_i,
    output logic [W-1:0] res_o,
    output logic         cout_o
);
    always_comb begin
        if (right_i) begin
            res_o  = {cin_i, a_i[W-1:1]};
            cout_o = a_i[0];
        end else begin
            res_o  = {a_i[W-2:0], cin_i};
            cout_o = a_i[W-1];
        end
    end
endmodule

// File: rtl/acc_alu_flags.sv
module acc_alu_flags
    import alu_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          exec_i,
    input  logic [2:0]    op_i,
    input  logic [DW-1:0] acc_i,
    input  logic [DW-1:0] opnd_i,
    output logic [DW-1:0] result_o,
    output logic          acc_we_o,
    output logic          c_nxt_o,
    output logic          z_nxt_o,
    output logic          c_we_o,
    output logic          z_we_o,
    output logic          c_o,
    output logic          z_o
);

    alu_op_e       op;
    flags_t        flags_d, flags_q;
    alu_out_t      out_d;
    logic [DW-1:0] log_res, ar_res, rot_res;
    logic          ar_cy, rot_cy, ar_sub, rot_right;

    assign op        = alu_op_e'(op_i);
    assign ar_sub    = (op == OP_SUB) || (op == OP_CMP);
    assign rot_right = (op == OP_ROR);

    alu_logic_unit #(.W(DW)) i_logic (
        .sel_or_i (op == OP_OR),
        .a_i      (acc_i),
        .b_i      (opnd_i),
        .res_o    (log_res)
    );

    alu_arith_unit #(.W(DW)) i_arith (
        .sub_i (ar_sub),
        .a_i   (acc_i),
        .b_i   (opnd_i),
        .res_o (ar_res),
        .cy_o  (ar_cy)
    );

    alu_rot_unit #(.W(DW)) i_rot (
        .right_i (rot_right),
        .cin_i   (flags_q.c),
        .a_i     (acc_i),
        .res_o   (rot_res),
        .cout_o  (rot_cy)
    );

    // Next-value process: datapath result, write enables and flag register input
    always_comb begin
        out_d = '0;
        unique case (op)
            OP_AND, OP_OR: begin
                out_d.res    = log_res;
                out_d.acc_we = 1'b1;
                out_d.z_we   = 1'b1;
                out_d.z_val  = (log_res == '0);
                out_d.c_val  = flags_q.c;
            end
            OP_ADD, OP_SUB: begin
                out_d.res    = ar_res;
                out_d.acc_we = 1'b1;
                out_d.c_we   = 1'b1;
                out_d.z_we   = 1'b1;
                out_d.c_val  = ar_cy;
                out_d.z_val  = (ar_res == '0);
            end
            OP_CMP: begin
                out_d.res    = ar_res;
                out_d.c_we   = 1'b1;
                out_d.z_we   = 1'b1;
                out_d.c_val  = ar_cy;
                out_d.z_val  = (ar_res == '0);
            end
            OP_ROL, OP_ROR: begin
                out_d.res    = rot_res;
                out_d.acc_we = 1'b1;
                out_d.c_we   = 1'b1;
                out_d.c_val  = rot_cy;
                out_d.z_val  = flags_q.z;
            end
            default: begin
                out_d.res    = acc_i;
                out_d.c_we   = 1'b1;
                out_d.z_we   = 1'b1;
            end
        endcase

        flags_d = flags_q;
        if (exec_i) begin
            if (out_d.c_we) flags_d.c = out_d.c_val;
            if (out_d.z_we) flags_d.z = out_d.z_val;
        end
    end

    // Register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    assign result_o = out_d.res;
    assign acc_we_o = out_d.acc_we;
    assign c_nxt_o  = out_d.c_val;
    assign z_nxt_o  = out_d.z_val;
    assign c_we_o   = out_d.c_we;
    assign z_we_o   = out_d.z_we;
    assign c_o      = flags_q.c;
    assign z_o      = flags_q.z;

    AST_FLAGS_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !exec_i |=> ($stable(c_o) && $stable(z_o))); // R8
    AST_LOGIC_KEEPS_C: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_i && (op_i == 3'd0 || op_i == 3'd1)) |=> $stable(c_o)); // R1
    AST_CMP_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd4) |-> !acc_we_o); // R4
    AST_CMP_Z_EQ: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_i && op_i == 3'd4) |=> (z_o == ($past(acc_i) == $past(opnd_i)))); // R4
    AST_ROT_KEEPS_Z: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_i && (op_i == 3'd5 || op_i == 3'd6)) |=> $stable(z_o)); // R5
    AST_CLF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_i && op_i == 3'd7) |=> (!c_o && !z_o)); // R7
    AST_ADD_Z_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_i && op_i == 3'd2) |=> (z_o == ($past(result_o) == '0))); // R2

endmodule

// File: tb/test_acc_alu_flags.sv
module test_acc_alu_flags;

    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       exec_i = 1'b0;
    logic [2:0] op_i = 3'd0;
    logic [7:0] acc_i = 8'h00;
    logic [7:0] opnd_i = 8'h00;
    logic [7:0] result_o;
    logic       acc_we_o, c_nxt_o, z_nxt_o, c_we_o, z_we_o, c_o, z_o;

    int n_checks = 0;
    int n_fails  = 0;

    typedef struct {
        logic [7:0] res;
        logic       we;
        logic       c;
        logic       z;
        string      tag;
    } exp_t;

    exp_t sb_q[$];
    logic mc = 1'b0;
    logic mz = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    acc_alu_flags i_acc_alu_flags (
        .clk(clk), .rst_n(rst_n), .exec_i(exec_i), .op_i(op_i),
        .acc_i(acc_i), .opnd_i(opnd_i), .result_o(result_o),
        .acc_we_o(acc_we_o), .c_nxt_o(c_nxt_o), .z_nxt_o(z_nxt_o),
        .c_we_o(c_we_o), .z_we_o(z_we_o), .c_o(c_o), .z_o(z_o)
    );

    task automatic check(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Driver: applies one operation on a falling edge and pushes its prediction
    task automatic drive(input logic ex, input logic [2:0] op, input logic [7:0] a,
                         input logic [7:0] b, input string tag);
        exp_t e;
        logic [8:0] w;
        logic nc, nz;
        nc = mc; nz = mz;
        e.we = 1'b1;
        case (op)
            3'd0: begin e.res = a & b; nz = (e.res == 8'h00); end
            3'd1: begin e.res = a | b; nz = (e.res == 8'h00); end
            3'd2: begin w = {1'b0, a} + {1'b0, b}; e.res = w[7:0]; nc = w[8]; nz = (e.res == 8'h00); end
            3'd3: begin e.res = a - b; nc = (b > a); nz = (e.res == 8'h00); end
            3'd4: begin e.res = a - b; e.we = 1'b0; nc = (b > a); nz = (a == b); end
            3'd5: begin e.res = {a[6:0], mc}; nc = a[7]; end
            3'd6: begin e.res = {mc, a[7:1]}; nc = a[0]; end
            default: begin e.res = a; e.we = 1'b0; nc = 1'b0; nz = 1'b0; end
        endcase
        if (ex) begin mc = nc; mz = nz; end
        e.c = mc; e.z = mz; e.tag = tag;
        @(negedge clk);
        exec_i = ex; op_i = op; acc_i = a; opnd_i = b;
        sb_q.push_back(e);
    endtask

    // Monitor: combinational outputs before the edge, flags after it
    initial begin
        forever begin
            exp_t e;
            @(negedge clk);
            #(CLK_PERIOD/4);
            if (sb_q.size() != 0) begin
                e = sb_q.pop_front();
                check(e.tag, "result (R10)", result_o, e.res);
                check(e.tag, "acc_we", {7'd0, acc_we_o}, {7'd0, e.we});
                @(posedge clk);
                #1;
                check(e.tag, "C flag", {7'd0, c_o}, {7'd0, e.c});
                check(e.tag, "Z flag", {7'd0, z_o}, {7'd0, e.z});
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        n_fails++;
        $display("FAIL watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R8", "reset C", {7'd0, c_o}, 8'd0);
        check("R8", "reset Z", {7'd0, z_o}, 8'd0);
        rst_n = 1'b1;
        // R2 carry out and zero
        drive(1, 3'd2, 8'hFF, 8'h01, "R2");
        // R1 AND zero result, C kept at 1
        drive(1, 3'd0, 8'hF0, 8'h0F, "R1");
        drive(1, 3'd1, 8'hA0, 8'h05, "R1");
        // R9 ADD with C set gives plain sum
        drive(1, 3'd2, 8'hFF, 8'h01, "R2");
        drive(1, 3'd2, 8'h10, 8'h22, "R9");
        drive(1, 3'd2, 8'h7F, 8'h01, "R2");
        // R3 borrow and no borrow
        drive(1, 3'd3, 8'h05, 8'h06, "R3");
        drive(1, 3'd3, 8'h30, 8'h10, "R9");
        drive(1, 3'd3, 8'h44, 8'h44, "R3");
        // R4 compare three ways
        drive(1, 3'd4, 8'h20, 8'h30, "R4");
        drive(1, 3'd4, 8'h55, 8'h55, "R4");
        drive(1, 3'd4, 8'h90, 8'h10, "R4");
        // R5 / R6 rotates through carry, Z kept
        drive(1, 3'd2, 8'hFF, 8'h01, "R2");
        drive(1, 3'd5, 8'h81, 8'h00, "R5");
        drive(1, 3'd5, 8'h00, 8'h00, "R5");
        drive(1, 3'd6, 8'h01, 8'h00, "R6");
        drive(1, 3'd6, 8'h02, 8'h00, "R6");
        drive(1, 3'd6, 8'h03, 8'h00, "R6");
        // R8 strobe low: no flag change
        drive(0, 3'd7, 8'h12, 8'h00, "R8");
        drive(0, 3'd2, 8'h01, 8'h01, "R8");
        // R7 clear flags
        drive(1, 3'd7, 8'h3C, 8'hFF, "R7");
        drive(1, 3'd1, 8'h00, 8'h00, "R1");
        drive(1, 3'd7, 8'h00, 8'h00, "R7");
        drive(0, 3'd0, 8'h00, 8'h00, "R8");
        repeat (4) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule